// File: doc/BRIEF.md
# Mantissa Rounding Unit with Selectable Precision and Direction

This block takes a mantissa that has not yet been rounded, along with the three extension bits below it (guard, round, sticky) and the sign of the value. It rounds the mantissa to a width chosen at run time and returns a mantissa of the same width. Every bit below the chosen width is cleared in the output. It also reports whether any discarded information was nonzero, whether the magnitude was incremented, and whether the increment carried out of the top bit, in which case the caller must add one to the exponent.

Two 2-bit fields select the operation. These fields are usually taken from a floating-point control register. The direction field picks one of four modes: nearest with ties to even, toward minus infinity, toward plus infinity, or chop. The precision field picks the short, middle or full width. With the default parameters these widths are 24, 53 and 64 bits. The result is registered and appears one clock after the inputs. Exponent range checks, pre-normalisation and denormal handling are the caller's job.

Top module: `mrnd_top`

## Requirements
- R1: Precision code `pc_i` selects the kept width: 2'b00 gives P_LO bits, 2'b10 gives P_MID bits, and 2'b11 or the reserved 2'b01 gives all W bits. The kept bits are the top bits of `mant_i`, and every output bit below the kept width is 0.
- R2: Direction code 2'b00 is nearest. The magnitude is incremented if the discarded part is above half an LSB. It is also incremented if the discarded part is exactly half and the kept LSB is 1. Otherwise the magnitude is kept.
- R3: Direction code 2'b01 rounds toward minus infinity. The magnitude is incremented exactly when the result is inexact and `sign_i` is 1.
- R4: Direction code 2'b10 rounds toward plus infinity. The magnitude is incremented exactly when the result is inexact and `sign_i` is 0.
- R5: Direction code 2'b11 chops. The magnitude is never incremented, and the kept bits pass through unchanged.
- R6: `inexact_o` is 1 exactly when any discarded bit is 1. The discarded bits are the `mant_i` bits below the kept width, plus guard, round and sticky.
- R7: `round_up_o` is 1 exactly when the magnitude was incremented by one kept LSB.
- R8: When the increment overflows the kept field, `mant_o` becomes a single 1 in bit W-1 with all other bits 0, and `exp_inc_o` is 1. Otherwise `exp_inc_o` is 0.
- R9: All outputs are registered, with one cycle of latency from the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mant_i | input | W | Unrounded mantissa, MSB at bit W-1 |
| guard_i | input | 1 | First bit below the mantissa |
| round_i | input | 1 | Second bit below the mantissa |
| sticky_i | input | 1 | OR of all lower bits |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| rc_i | input | 2 | Rounding direction code |
| pc_i | input | 2 | Precision code |
| mant_o | output | W | Rounded mantissa, low bits cleared |
| exp_inc_o | output | 1 | Carry out of rounding, exponent must increase |
| inexact_o | output | 1 | Discarded information was nonzero |
| round_up_o | output | 1 | Magnitude was incremented |

## Verification
The hardest case to reach from the ports is the carry out of the kept field. It needs every kept bit at 1, for the width currently selected, together with a discarded pattern that forces an increment under the current direction and sign. Nearest ties are similarly narrow: they need exactly the half bit set, and the result depends on the kept LSB. The bench uses a narrow instance (8-bit mantissa, widths 3, 5 and 8). On it, the bench sweeps every mantissa, every guard/round/sticky combination, both signs, all four directions and all four precision codes. This reaches every all-ones and exact-half pattern at every width.

// File: rtl/mrnd_pkg.sv
package mrnd_pkg;

    typedef enum logic [1:0] {
        RC_NEAREST = 2'b00,
        RC_TO_NEG  = 2'b01,
        RC_TO_POS  = 2'b10,
        RC_CHOP    = 2'b11
    } rc_mode_e;

    typedef enum logic [1:0] {
        PC_SHORT = 2'b00,
        PC_RSVD  = 2'b01,
        PC_MID   = 2'b10,
        PC_FULL  = 2'b11
    } pc_code_e;

    // number of extended bits (mantissa plus guard/round/sticky) below the kept LSB
    function automatic int unsigned drop_count(input int unsigned w, input int unsigned p);
        return w - p + 3;
    endfunction

endpackage

// File: rtl/mrnd_prec_sel.sv
module mrnd_prec_sel
    import mrnd_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned P_LO  = 24,
    parameter int unsigned P_MID = 53,
    parameter int unsigned SW    = 7
) (
    input  logic [1:0]    pc_i,
    output logic [SW-1:0] drop_o
);

    logic [SW-1:0] drop_tbl [4];

    generate
        for (genvar c = 0; c < 4; c++) begin : g_code
            localparam int unsigned PW = (c == int'(PC_SHORT)) ? P_LO :
                                         (c == int'(PC_MID))   ? P_MID : W;
            assign drop_tbl[c] = SW'(drop_count(W, PW));
        end
    endgenerate

    assign drop_o = drop_tbl[pc_i];

endmodule

// File: rtl/mrnd_decide.sv
module mrnd_decide
    import mrnd_pkg::*;
#(
    parameter int unsigned EW = 67,
    parameter int unsigned SW = 7
) (
    input  logic [EW-1:0] ext_i,
    input  logic [SW-1:0] drop_i,
    input  logic [1:0]    rc_i,
    input  logic          sign_i,
    output logic          inexact_o,
    output logic          incr_o
);

    localparam logic [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

    logic [EW-1:0] lsb_m;
    logic [EW-1:0] half_m;
    logic [EW-1:0] rest_m;
    logic          lsb_b;
    logic          half_b;
    logic          rest_b;

    always_comb begin
        lsb_m     = ONE << drop_i;
        half_m    = lsb_m >> 1;
        rest_m    = half_m - ONE;
        lsb_b     = |(ext_i & lsb_m);
        half_b    = |(ext_i & half_m);
        rest_b    = |(ext_i & rest_m);
        inexact_o = half_b | rest_b;
        case (rc_mode_e'(rc_i))
            RC_NEAREST: incr_o = half_b & (rest_b | lsb_b);
            RC_TO_NEG:  incr_o = inexact_o & sign_i;
            RC_TO_POS:  incr_o = inexact_o & ~sign_i;
            default:    incr_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mrnd_incr.sv
module mrnd_incr #(
    parameter int unsigned W  = 64,
    parameter int unsigned EW = 67,
    parameter int unsigned SW = 7
) (
    input  logic [EW-1:0] ext_i,
    input  logic [SW-1:0] drop_i,
    input  logic          incr_i,
    output logic [W-1:0]  mant_o,
    output logic          carry_o
);

    localparam logic [EW-1:0] ONE = {{(EW-1){1'b0}}, 1'b1};

    logic [EW-1:0] lsb_m;
    logic [EW-1:0] keep_m;
    logic [EW:0]   sum;

    always_comb begin
        lsb_m   = ONE << drop_i;
        keep_m  = ~(lsb_m - ONE);
        sum     = {1'b0, ext_i & keep_m} + (incr_i ? {1'b0, lsb_m} : '0);
        carry_o = sum[EW];
        mant_o  = carry_o ? {1'b1, {(W-1){1'b0}}} : sum[EW-1:3];
    end

endmodule

// File: rtl/mrnd_top.sv
module mrnd_top #(
    parameter int unsigned W     = 64,
    parameter int unsigned P_LO  = 24,
    parameter int unsigned P_MID = 53
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] mant_i,
    input  logic         guard_i,
    input  logic         round_i,
    input  logic         sticky_i,
    input  logic         sign_i,
    input  logic [1:0]   rc_i,
    input  logic [1:0]   pc_i,
    output logic [W-1:0] mant_o,
    output logic         exp_inc_o,
    output logic         inexact_o,
    output logic         round_up_o
);

    localparam int unsigned EW = W + 3;
    localparam int unsigned SW = $clog2(EW + 1);

    typedef struct packed {
        logic [W-1:0] mant;
        logic         exp_inc;
        logic         inexact;
        logic         round_up;
    } res_t;

    res_t st_d;
    res_t st_q;

    logic [EW-1:0] ext;
    logic [SW-1:0] drop;
    logic          inx;
    logic          incr;
    logic [W-1:0]  rnd_mant;
    logic          carry;

    assign ext = {mant_i, guard_i, round_i, sticky_i};

    mrnd_prec_sel #(.W(W), .P_LO(P_LO), .P_MID(P_MID), .SW(SW)) sel_i (
        .pc_i   (pc_i),
        .drop_o (drop)
    );

    mrnd_decide #(.EW(EW), .SW(SW)) dec_i (
        .ext_i     (ext),
        .drop_i    (drop),
        .rc_i      (rc_i),
        .sign_i    (sign_i),
        .inexact_o (inx),
        .incr_o    (incr)
    );

    mrnd_incr #(.W(W), .EW(EW), .SW(SW)) inc_i (
        .ext_i   (ext),
        .drop_i  (drop),
        .incr_i  (incr),
        .mant_o  (rnd_mant),
        .carry_o (carry)
    );

    always_comb begin
        st_d          = st_q;
        st_d.mant     = rnd_mant;
        st_d.exp_inc  = carry;
        st_d.inexact  = inx;
        st_d.round_up = incr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mant_o     = st_q.mant;
    assign exp_inc_o  = st_q.exp_inc;
    assign inexact_o  = st_q.inexact;
    assign round_up_o = st_q.round_up;

endmodule

// File: rtl/mrnd_chk.sv
module mrnd_chk #(
    parameter int unsigned W    = 64,
    parameter int unsigned P_LO = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   rc_i,
    input logic [1:0]   pc_i,
    input logic [W-1:0] mant_o,
    input logic         exp_inc_o,
    input logic         inexact_o,
    input logic         round_up_o
);

    // R8
    carry_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_inc_o |-> (mant_o == {1'b1, {(W-1){1'b0}}}));

    // R7
    carry_needs_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_inc_o |-> round_up_o);

    // R7
    up_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_up_o |-> inexact_o);

    // R5
    chop_no_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rc_i == 2'b11) |=> !round_up_o);

    // R1
    short_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_i == 2'b00) |=> (mant_o[W-P_LO-1:0] == '0));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (mant_o == '0 && !exp_inc_o && !inexact_o && !round_up_o));

endmodule

bind mrnd_top mrnd_chk #(.W(W), .P_LO(P_LO)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rc_i       (rc_i),
    .pc_i       (pc_i),
    .mant_o     (mant_o),
    .exp_inc_o  (exp_inc_o),
    .inexact_o  (inexact_o),
    .round_up_o (round_up_o)
);

// File: tb/mrnd_top_tb_top.sv
`timescale 1ns/1ps
module mrnd_top_tb_top;

    localparam int W     = 8;
    localparam int P_LO  = 3;
    localparam int P_MID = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] mant_i = '0;
    logic         guard_i = 1'b0;
    logic         round_i = 1'b0;
    logic         sticky_i = 1'b0;
    logic         sign_i = 1'b0;
    logic [1:0]   rc_i = 2'b00;
    logic [1:0]   pc_i = 2'b11;
    logic [W-1:0] mant_o;
    logic         exp_inc_o;
    logic         inexact_o;
    logic         round_up_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    mrnd_top #(.W(W), .P_LO(P_LO), .P_MID(P_MID)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mant_i     (mant_i),
        .guard_i    (guard_i),
        .round_i    (round_i),
        .sticky_i   (sticky_i),
        .sign_i     (sign_i),
        .rc_i       (rc_i),
        .pc_i       (pc_i),
        .mant_o     (mant_o),
        .exp_inc_o  (exp_inc_o),
        .inexact_o  (inexact_o),
        .round_up_o (round_up_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int prec_of(input int pc);
        if (pc == 0) return P_LO;
        if (pc == 2) return P_MID;
        return W;
    endfunction

    initial begin
        int e_mant, e_inx, e_up, e_ci;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(mant_o == '0 && !exp_inc_o && !inexact_o && !round_up_o, "R9 reset",
            int'(mant_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int rc = 0; rc < 4; rc++) begin
            for (int pc = 0; pc < 4; pc++) begin
                for (int sg = 0; sg < 2; sg++) begin
                    for (int m = 0; m < 256; m++) begin
                        for (int grs = 0; grs < 8; grs++) begin
                            int p, drop, ext, q, rem, half;
                            string tag;
                            @(negedge clk);
                            mant_i   = W'(m);
                            guard_i  = grs[2];
                            round_i  = grs[1];
                            sticky_i = grs[0];
                            sign_i   = sg[0];
                            rc_i     = 2'(rc);
                            pc_i     = 2'(pc);
                            p    = prec_of(pc);
                            drop = W - p + 3;
                            ext  = m * 8 + grs;
                            q    = ext >> drop;
                            rem  = ext & ((1 << drop) - 1);
                            half = 1 << (drop - 1);
                            e_inx = (rem != 0) ? 1 : 0;
                            case (rc)
                                0: e_up = (rem > half || (rem == half && (q % 2) == 1)) ? 1 : 0;
                                1: e_up = (e_inx == 1 && sg == 1) ? 1 : 0;
                                2: e_up = (e_inx == 1 && sg == 0) ? 1 : 0;
                                default: e_up = 0;
                            endcase
                            q = q + e_up;
                            e_ci = 0;
                            if (q == (1 << p)) begin
                                e_ci = 1;
                                q = 1 << (p - 1);
                            end
                            e_mant = q << (W - p);
                            @(posedge clk);
                            #2;
                            case (rc)
                                0: tag = "R2 nearest mant";
                                1: tag = "R3 to-minus mant";
                                2: tag = "R4 to-plus mant";
                                default: tag = "R5 chop mant";
                            endcase
                            chk(int'(mant_o) == e_mant, tag, int'(mant_o), e_mant);
                            chk((int'(mant_o) & ((1 << (W - p)) - 1)) == 0, "R1 low bits",
                                int'(mant_o), e_mant);
                            chk(int'(inexact_o) == e_inx, "R6 inexact", int'(inexact_o), e_inx);
                            chk(int'(round_up_o) == e_up, "R7 round_up", int'(round_up_o), e_up);
                            chk(int'(exp_inc_o) == e_ci, "R8 exp_inc", int'(exp_inc_o), e_ci);
                        end
                    end
                end
            end
        end
        // R9: output holds until the next edge
        @(negedge clk);
        rc_i = 2'b11; pc_i = 2'b11; mant_i = 8'h5A;
        guard_i = 1'b0; round_i = 1'b0; sticky_i = 1'b0;
        @(posedge clk);
        #2;
        chk(mant_o == 8'h5A, "R9 capture", int'(mant_o), 'h5A);
        @(negedge clk);
        mant_i = 8'h33;
        #1;
        chk(mant_o == 8'h5A, "R9 latency", int'(mant_o), 'h5A);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule